// File: doc/BRIEF.md
# Serial Equalizer Control Receiver

This block takes control words for a 14-band stereo graphic equalizer over a slow three-wire serial link. The three wires are a shift clock, a data line and a load strobe. The strobe is a transfer pulse that moves the last eight shifted bits into the decoder. The top bit of each word sets its type. A band word picks the target band and sets the gain range of each channel. A gain word sets the boost/cut sense and the resistor-tap pattern of the band picked before it.

The outputs hold the full switch state of every band in parallel, and all of it is registered. Each band has a boost flag, a six-bit tap-enable vector and a half-range flag. The outputs also give the currently selected band. There are two one-cycle error pulses: one for a tap code that is not in the table, and one for a gain word that arrives when no band is selected. The three serial wires are asynchronous to the system clock. Each passes through a two-flop synchronizer before edge detection.

Top module: `eq_ctrl_rx`

## Requirements
- R1: Data is sampled on each synchronized rising edge of `ser_clk` and shifted in least significant bit first. At a strobe rising edge, the last eight bits become the word: the first bit becomes W[0] and the eighth becomes W[7].
- R2: A word with W[7]=1 is a band word. If W[3:0] is 1..14, `sel_band` becomes that value. If W[3:0] is 0 or 15, `sel_band` becomes 0, meaning no band.
- R3: A band word always loads two range bits: W[5] for channel A (bands 1..7) and W[4] for channel B (bands 8..14). A value of 1 selects the half range. `band_half[n-1]` shows the range of band n. W[6] has no effect.
- R4: A word with W[7]=0 is a gain word for band `sel_band`. That band's field `band_taps[(n-1)*6 +: 6]` becomes W[5:0], and its flag `band_boost[n-1]` becomes W[6] (1 = boost).
- R5: Tap code 0 is flat. A flat band has all taps clear and `band_boost` at 0, whatever the value of W[6].
- R6: The legal tap codes are 0x00, 0x20, 0x10, 0x08, 0x04, 0x02, 0x12, 0x2A, 0x16, 0x01, 0x29, 0x2D and 0x2F. A gain word with any other code stores flat for the band and pulses `code_err` high for one cycle.
- R7: A gain word that arrives while `sel_band` is 0 changes no band state and pulses `orphan_err` high for one cycle.
- R8: The band selection persists across gain words, so later gain words reach the same band without a new band word. Bands that are not selected never change.
- R9: While `rst` is high, and after it, all bands are flat with boost 0, both ranges are full (`band_half` all 0), `sel_band` is 0 and both error pulses are low.
- R10: Every output, including the error pulses, changes on the fourth system clock edge after the strobe input rises, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, LSB first |
| ser_stb | input | 1 | Load strobe, acts on rising edge |
| band_taps | output | 84 | Six tap enables per band, band n at bits (n-1)*6 +: 6 |
| band_boost | output | 14 | Boost flag per band (0 = cut or flat) |
| band_half | output | 14 | Half-range flag per band, from its channel |
| sel_band | output | 4 | Selected band, 0 = none |
| orphan_err | output | 1 | One-cycle pulse: gain word with no band selected |
| code_err | output | 1 | One-cycle pulse: tap code not in table |

## Verification
A strobe edge reaches the outputs after two synchronizer stages, one edge-detect and word-load register, and one decode register, so every result is due on the fourth clock edge after the strobe input rises. For each word, the bench first samples three edges after the strobe, where it expects the previous state. It then samples after the fourth edge and compares the new state and the error pulses against its model. It samples once more to confirm that each pulse lasts exactly one cycle. Serial bits are held for four system cycles on each side of every shift-clock edge, so the synchronized data is stable when it is sampled.

// File: rtl/eqrx_pkg.sv
package eqrx_pkg;
  localparam int WORD_W = 8;
  localparam int TAP_W  = 6;
  localparam int BAND_W = 4;

  // Tap patterns permitted by the switch network (bit 5 = first tap)
  function automatic logic tap_code_ok(input logic [TAP_W-1:0] c);
    case (c)
      6'h00, 6'h20, 6'h10, 6'h08, 6'h04, 6'h02, 6'h12,
      6'h2A, 6'h16, 6'h01, 6'h29, 6'h2D, 6'h2F: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/eqrx_sync.sv
module eqrx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/eqrx_shift.sv
module eqrx_shift
  import eqrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              stb_s,
  output logic [WORD_W-1:0] word,
  output logic              word_vld
);
  logic              sclk_d, stb_d;
  logic [WORD_W-1:0] sh_q;
  logic              sclk_rise, stb_rise;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign stb_rise  = stb_s & ~stb_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d   <= 1'b0;
      stb_d    <= 1'b0;
      sh_q     <= '0;
      word     <= '0;
      word_vld <= 1'b0;
    end else begin
      sclk_d   <= sclk_s;
      stb_d    <= stb_s;
      word_vld <= stb_rise;
      if (sclk_rise) sh_q <= {sdat_s, sh_q[WORD_W-1:1]};
      if (stb_rise)  word <= sh_q;
    end
  end
endmodule

// File: rtl/eqrx_decode.sv
module eqrx_decode
  import eqrx_pkg::*;
#(
  parameter int BANDS_PER_CH = 7,
  localparam int NB    = 2 * BANDS_PER_CH,
  localparam int SEL_W = $clog2(NB + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [WORD_W-1:0]   word,
  input  logic                word_vld,
  output logic [NB*TAP_W-1:0] band_taps,
  output logic [NB-1:0]       band_boost,
  output logic [NB-1:0]       band_half,
  output logic [SEL_W-1:0]    sel_band,
  output logic                orphan_err,
  output logic                code_err
);
  logic [TAP_W-1:0]  tap_q [NB];
  logic [NB-1:0]     boost_q;
  logic              half_a_q, half_b_q;
  logic [SEL_W-1:0]  sel_q;
  logic              orphan_q, code_q;

  logic              is_band_word, band_hit, gain_ok;
  logic [BAND_W-1:0] bcode;
  logic [SEL_W-1:0]  wr_idx;

  always_comb begin
    is_band_word = word[WORD_W-1];
    bcode        = word[BAND_W-1:0];
    band_hit     = (bcode != '0) && (int'(bcode) <= NB);
    gain_ok      = tap_code_ok(word[TAP_W-1:0]);
    wr_idx       = sel_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NB; b++) tap_q[b] <= '0;
      boost_q  <= '0;
      half_a_q <= 1'b0;
      half_b_q <= 1'b0;
      sel_q    <= '0;
      orphan_q <= 1'b0;
      code_q   <= 1'b0;
    end else begin
      orphan_q <= 1'b0;
      code_q   <= 1'b0;
      if (word_vld) begin
        if (is_band_word) begin
          sel_q    <= band_hit ? SEL_W'(bcode) : '0;
          half_a_q <= word[5];
          half_b_q <= word[4];
        end else if (sel_q == '0) begin
          orphan_q <= 1'b1;
        end else begin
          tap_q[wr_idx]   <= gain_ok ? word[TAP_W-1:0] : '0;
          boost_q[wr_idx] <= gain_ok && (word[TAP_W-1:0] != '0) && word[6];
          code_q          <= ~gain_ok;
        end
      end
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_out
    assign band_taps[b*TAP_W +: TAP_W] = tap_q[b];
    assign band_half[b] = (b < BANDS_PER_CH) ? half_a_q : half_b_q;
  end

  assign band_boost = boost_q;
  assign sel_band   = sel_q;
  assign orphan_err = orphan_q;
  assign code_err   = code_q;
endmodule

// File: rtl/eq_ctrl_rx.sv
module eq_ctrl_rx
  import eqrx_pkg::*;
#(
  parameter int BANDS_PER_CH = 7,
  parameter int SYNC_STAGES  = 2,
  localparam int NB    = 2 * BANDS_PER_CH,
  localparam int SEL_W = $clog2(NB + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ser_clk,
  input  logic                ser_data,
  input  logic                ser_stb,
  output logic [NB*TAP_W-1:0] band_taps,
  output logic [NB-1:0]       band_boost,
  output logic [NB-1:0]       band_half,
  output logic [SEL_W-1:0]    sel_band,
  output logic                orphan_err,
  output logic                code_err
);
  logic [2:0]        pins_s;
  logic [WORD_W-1:0] word;
  logic              word_vld;

  eqrx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({ser_stb, ser_data, ser_clk}),
    .dout (pins_s)
  );

  eqrx_shift u_shift (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (pins_s[0]),
    .sdat_s   (pins_s[1]),
    .stb_s    (pins_s[2]),
    .word     (word),
    .word_vld (word_vld)
  );

  eqrx_decode #(.BANDS_PER_CH(BANDS_PER_CH)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .word       (word),
    .word_vld   (word_vld),
    .band_taps  (band_taps),
    .band_boost (band_boost),
    .band_half  (band_half),
    .sel_band   (sel_band),
    .orphan_err (orphan_err),
    .code_err   (code_err)
  );
endmodule

// File: rtl/eqrx_chk.sv
module eqrx_chk
  import eqrx_pkg::*;
#(
  parameter int BANDS_PER_CH = 7,
  localparam int NB    = 2 * BANDS_PER_CH,
  localparam int SEL_W = $clog2(NB + 1)
) (
  input logic                clk,
  input logic                rst,
  input logic [NB*TAP_W-1:0] band_taps,
  input logic [NB-1:0]       band_boost,
  input logic [NB-1:0]       band_half,
  input logic [SEL_W-1:0]    sel_band,
  input logic                orphan_err,
  input logic                code_err
);
  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (band_taps == '0 && band_boost == '0 && band_half == '0 &&
             sel_band == '0 && !orphan_err && !code_err));

  // R2
  sel_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(sel_band) <= NB);

  // R3
  half_group_chk: assert property (@(posedge clk) disable iff (rst)
    band_half[BANDS_PER_CH-1:0] == {BANDS_PER_CH{band_half[0]}} &&
    band_half[NB-1:BANDS_PER_CH] == {BANDS_PER_CH{band_half[BANDS_PER_CH]}});

  // R7
  orphan_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    orphan_err |=> !orphan_err);

  // R6
  code_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    code_err |=> !code_err);

  // R7
  err_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(orphan_err && code_err));

  for (genvar b = 0; b < NB; b++) begin : g_band
    // R6
    tap_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
      tap_code_ok(band_taps[b*TAP_W +: TAP_W]));
    // R5
    flat_no_boost_chk: assert property (@(posedge clk) disable iff (rst)
      (band_taps[b*TAP_W +: TAP_W] == '0) |-> !band_boost[b]);
    // R8
    single_band_write_chk: assert property (@(posedge clk) disable iff (rst)
      (!$stable(band_taps[b*TAP_W +: TAP_W]) || !$stable(band_boost[b]))
        |-> int'(sel_band) == b + 1);
  end
endmodule

bind eq_ctrl_rx eqrx_chk #(.BANDS_PER_CH(BANDS_PER_CH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .band_taps  (band_taps),
  .band_boost (band_boost),
  .band_half  (band_half),
  .sel_band   (sel_band),
  .orphan_err (orphan_err),
  .code_err   (code_err)
);

// File: tb/eq_ctrl_rx_test.sv
`timescale 1ns/1ps
module eq_ctrl_rx_test;
  localparam int NB = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_stb = 1'b0;
  logic [NB*6-1:0] band_taps;
  logic [NB-1:0]   band_boost, band_half;
  logic [3:0]      sel_band;
  logic            orphan_err, code_err;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [5:0] m_taps [NB];
  logic       m_boost [NB];
  logic       m_ha, m_hb;
  int         m_sel;
  logic       m_orph, m_code;

  always #4 clk = ~clk;

  eq_ctrl_rx uut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_stb(ser_stb), .band_taps(band_taps), .band_boost(band_boost),
    .band_half(band_half), .sel_band(sel_band),
    .orphan_err(orphan_err), .code_err(code_err)
  );

  function automatic logic legal(input logic [5:0] c);
    logic [5:0] tbl [13] = '{6'h00, 6'h20, 6'h10, 6'h08, 6'h04, 6'h02,
                             6'h12, 6'h2A, 6'h16, 6'h01, 6'h29, 6'h2D, 6'h2F};
    foreach (tbl[i]) if (tbl[i] == c) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [5:0] pick_code();
    logic [5:0] tbl [13] = '{6'h00, 6'h20, 6'h10, 6'h08, 6'h04, 6'h02,
                             6'h12, 6'h2A, 6'h16, 6'h01, 6'h29, 6'h2D, 6'h2F};
    if ($urandom_range(99) < 80) return tbl[$urandom_range(12)];
    return 6'($urandom);
  endfunction

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin m_taps[b] = '0; m_boost[b] = 1'b0; end
    m_ha = 1'b0; m_hb = 1'b0; m_sel = 0; m_orph = 1'b0; m_code = 1'b0;
  endtask

  task automatic model_apply(input logic [7:0] w);
    m_orph = 1'b0; m_code = 1'b0;
    if (w[7]) begin
      m_sel = (w[3:0] >= 1 && w[3:0] <= 14) ? int'(w[3:0]) : 0;
      m_ha = w[5]; m_hb = w[4];
    end else if (m_sel == 0) begin
      m_orph = 1'b1;
    end else if (!legal(w[5:0])) begin
      m_taps[m_sel-1] = '0; m_boost[m_sel-1] = 1'b0; m_code = 1'b1;
    end else begin
      m_taps[m_sel-1]  = w[5:0];
      m_boost[m_sel-1] = (w[5:0] != 0) && w[6];
    end
  endtask

  task automatic check1(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag, input logic eo, input logic ec);
    logic [NB*6-1:0] et;
    logic [NB-1:0]   eb, eh;
    for (int b = 0; b < NB; b++) begin
      et[b*6 +: 6] = m_taps[b];
      eb[b] = m_boost[b];
      eh[b] = (b < 7) ? m_ha : m_hb;
    end
    check1({tag, " R4 taps"}, 128'(band_taps), 128'(et));
    check1({tag, " R5 boost"}, 128'(band_boost), 128'(eb));
    check1({tag, " R3 half"}, 128'(band_half), 128'(eh));
    check1({tag, " R2 sel"}, 128'(sel_band), 128'(m_sel));
    check1({tag, " R7 orphan_err"}, 128'(orphan_err), 128'(eo));
    check1({tag, " R6 code_err"}, 128'(code_err), 128'(ec));
  endtask

  // R1: shift LSB first, four system cycles around each serial edge
  task automatic send(input logic [7:0] w, input string tag);
    for (int i = 0; i < 8; i++) begin
      ser_data = w[i];
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (4) @(negedge clk);
    ser_stb = 1'b1;
    repeat (3) @(negedge clk);
    compare_all({tag, " R10 early"}, 1'b0, 1'b0);
    model_apply(w);
    @(negedge clk);
    compare_all({tag, " R10 due"}, m_orph, m_code);
    @(negedge clk);
    compare_all({tag, " R7 R6 pulse end"}, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    ser_stb = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
    compare_all({tag, " R9 in reset"}, 1'b0, 1'b0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    compare_all({tag, " R9 after reset"}, 1'b0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0835));
    model_reset();
    do_reset("init");
    send(8'h4F, "R7 orphan gain");
    send(8'hE3, "R1 R3 band3 ranges D6 set");
    send(8'h6F, "R4 12dB boost");
    send(8'h01, "R8 resend 9dB cut no band word");
    send(8'h3F, "R6 illegal code");
    send(8'h2D, "R4 11dB cut");
    send(8'h40, "R5 flat with boost bit");
    send(8'h9E, "R2 band14 chan B");
    send(8'h52, "R4 band14 gain");
    send(8'hA7, "R3 band7 chan A");
    send(8'h6A, "R4 band7 gain");
    send(8'h8F, "R2 code15 no band");
    send(8'h29, "R7 orphan after none");
    send(8'h80, "R2 code0 no band");
    send(8'h8B, "R1 band11 bit order");
    send(8'h56, "R8 band11 gain");
    for (int n = 0; n < 240; n++) begin
      logic [7:0] w;
      if ($urandom_range(99) < 35) w = {1'b1, 7'($urandom)};
      else w = {1'b0, 1'($urandom), pick_code()};
      send(w, "random");
    end
    do_reset("R9 mid-run");
    send(8'h16, "R7 orphan after reset");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule